// File: doc/BRIEF.md
# Prioritized Loadable Up/Down Counter

This block is a synchronous binary counter. Several control inputs compete for its next value. An enable gates the ordinary work: counting up or down, and a parallel load from a data bus. Two strobes act whether or not the counter is enabled. One forces a fixed preset constant. The other, a synchronous reset, clears the count.

The winner in each cycle comes from a fixed priority ladder. By default the ladder is, from strongest to weakest: clear, preset, load, count, hold. A build parameter can swap the top two rungs, so that preset beats clear. Counting wraps modulo 2^WIDTH. Every change, including the clear, takes effect on the rising clock edge only.

The block is meant for timers, address generators and sequencers that need predictable results when strobes overlap.

Top module: `prio_updown_counter`

## Requirements
- R1: The count changes only on a rising clock edge. After an edge with `rst_i` high, `count_o` reads 0.
- R2: When `en_i`=1, `up_i`=1 and no load, preset or reset is active, the count rises by one per edge. From all-ones it wraps to 0.
- R3: When `en_i`=1, `up_i`=0 and no load, preset or reset is active, the count falls by one per edge. From 0 it wraps to all-ones.
- R4: When `en_i`=0 and neither preset nor reset is active, the count holds. `up_i` and `din_i` have no effect.
- R5: When `en_i`=1 and `load_i`=1 with no preset or reset, the count takes `din_i`. This beats counting in either direction.
- R6: When `en_i`=0, `load_i` is ignored and the count holds.
- R7: When `preset_i`=1 and no reset is active, the count becomes PRESET_VAL (default 9, zero-extended). This happens whether `en_i` is high or low, and it beats load and counting.
- R8: With PRESET_WINS=0 (the default), `rst_i`=1 clears the count to 0 even when preset, load and enable are all active.
- R9: With PRESET_WINS=1, preset beats reset: when both are active the count becomes PRESET_VAL. Reset alone still clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; every update happens on its rising edge |
| rst_i | input | 1 | Synchronous clear, active high |
| en_i | input | 1 | Enable; gates counting and load |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| load_i | input | 1 | Parallel load strobe (takes effect only while enabled) |
| din_i | input | WIDTH | Parallel load value |
| preset_i | input | 1 | Forces the count to PRESET_VAL regardless of enable |
| count_o | output | WIDTH | Current count |

## Verification
The bench builds two copies side by side, both 8 bits wide with a preset value of 9. One copy keeps the default ladder and the other sets PRESET_WINS=1. Each cycle, the same stimulus drives both copies. This shows in a single run that the reset/preset collision resolves one way in one build and the opposite way in the other. The 8-bit width keeps both wrap points (0xFF to 0x00 and back) a short walk away. The random phase asserts all strobes together often enough to exercise every rung of the ladder.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

    // Which rung of the priority ladder decides the next count.
    typedef enum logic [2:0] {
        ACT_HOLD   = 3'd0,
        ACT_COUNT  = 3'd1,
        ACT_LOAD   = 3'd2,
        ACT_PRESET = 3'd3,
        ACT_CLEAR  = 3'd4
    } pcnt_act_e;

endpackage

// File: rtl/pcnt_arbiter.sv
module pcnt_arbiter
    import pcnt_pkg::*;
#(
    parameter bit PRESET_WINS = 1'b0
) (
    input  logic      rst_i,
    input  logic      en_i,
    input  logic      load_i,
    input  logic      preset_i,
    output pcnt_act_e act_o
);

    // Scheduled style: start from the weakest rung. Each later statement
    // overrides the earlier ones, so it sits nearer the output.
    generate
        if (PRESET_WINS) begin : g_preset_top
            always_comb begin
                act_o = ACT_HOLD;
                if (en_i) begin
                    act_o = ACT_COUNT;
                    if (load_i) act_o = ACT_LOAD;
                end
                if (rst_i)    act_o = ACT_CLEAR;
                if (preset_i) act_o = ACT_PRESET;
            end
        end else begin : g_clear_top
            always_comb begin
                act_o = ACT_HOLD;
                if (en_i) begin
                    act_o = ACT_COUNT;
                    if (load_i) act_o = ACT_LOAD;
                end
                if (preset_i) act_o = ACT_PRESET;
                if (rst_i)    act_o = ACT_CLEAR;
            end
        end
    endgenerate

endmodule

// File: rtl/pcnt_stepper.sv
module pcnt_stepper #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur_i,
    input  logic             up_i,
    output logic [WIDTH-1:0] nxt_o
);

    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    // Plain modular arithmetic: the carry out is dropped, which gives the wrap.
    always_comb begin
        if (up_i) nxt_o = cur_i + STEP;
        else      nxt_o = cur_i - STEP;
    end

endmodule

// File: rtl/prio_updown_counter.sv
module prio_updown_counter
    import pcnt_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int PRESET_VAL  = 9,
    parameter bit PRESET_WINS = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             up_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic             preset_i,
    output logic [WIDTH-1:0] count_o
);

    localparam logic [WIDTH-1:0] PRESET_W = WIDTH'(PRESET_VAL);
    localparam logic [WIDTH-1:0] ZERO_W   = '0;

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    pcnt_act_e        act;
    logic [WIDTH-1:0] step_val;

    pcnt_arbiter #(
        .PRESET_WINS(PRESET_WINS)
    ) u_arb (
        .rst_i    (rst_i),
        .en_i     (en_i),
        .load_i   (load_i),
        .preset_i (preset_i),
        .act_o    (act)
    );

    pcnt_stepper #(
        .WIDTH(WIDTH)
    ) u_step (
        .cur_i (st_q.cnt),
        .up_i  (up_i),
        .nxt_o (step_val)
    );

    // Next value: hold by default, so that no path leaves a latch behind.
    always_comb begin
        st_d = st_q;
        case (act)
            ACT_COUNT:  st_d.cnt = step_val;
            ACT_LOAD:   st_d.cnt = din_i;
            ACT_PRESET: st_d.cnt = PRESET_W;
            ACT_CLEAR:  st_d.cnt = ZERO_W;
            default:    st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign count_o = st_q.cnt;

endmodule

// File: rtl/pcnt_checker.sv
module pcnt_checker #(
    parameter int WIDTH       = 8,
    parameter int PRESET_VAL  = 9,
    parameter bit PRESET_WINS = 1'b0
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             en_i,
    input logic             up_i,
    input logic             load_i,
    input logic [WIDTH-1:0] din_i,
    input logic             preset_i,
    input logic [WIDTH-1:0] count_o
);

    localparam logic [WIDTH-1:0] PV = WIDTH'(PRESET_VAL);

    // Set once a reset has been sampled. Until then the count is not defined.
    logic seen_rst_q;
    always_ff @(posedge clk_i) begin
        if (rst_i) seen_rst_q <= 1'b1;
    end

    p_count_up_r2: assert property (@(posedge clk_i) disable iff (!seen_rst_q)
        (en_i && up_i && !load_i && !preset_i && !rst_i)
            |=> count_o == WIDTH'($past(count_o) + 1'b1));

    p_count_down_r3: assert property (@(posedge clk_i) disable iff (!seen_rst_q)
        (en_i && !up_i && !load_i && !preset_i && !rst_i)
            |=> count_o == WIDTH'($past(count_o) - 1'b1));

    // R4 and R6: a disabled counter holds, even with load asserted.
    p_hold_r4: assert property (@(posedge clk_i) disable iff (!seen_rst_q)
        (!en_i && !preset_i && !rst_i) |=> count_o == $past(count_o));

    p_load_r5: assert property (@(posedge clk_i) disable iff (!seen_rst_q)
        (en_i && load_i && !preset_i && !rst_i) |=> count_o == $past(din_i));

    p_preset_r7: assert property (@(posedge clk_i) disable iff (!seen_rst_q)
        (preset_i && !rst_i) |=> count_o == PV);

    generate
        if (PRESET_WINS) begin : g_swap
            p_preset_wins_r9: assert property (@(posedge clk_i) disable iff (!seen_rst_q)
                preset_i |=> count_o == PV);
            p_clear_alone_r9: assert property (@(posedge clk_i) disable iff (!seen_rst_q)
                (rst_i && !preset_i) |=> count_o == '0);
        end else begin : g_norm
            p_clear_r8: assert property (@(posedge clk_i) disable iff (!seen_rst_q)
                rst_i |=> count_o == '0);
        end
    endgenerate

endmodule

bind prio_updown_counter pcnt_checker #(
    .WIDTH       (WIDTH),
    .PRESET_VAL  (PRESET_VAL),
    .PRESET_WINS (PRESET_WINS)
) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .en_i     (en_i),
    .up_i     (up_i),
    .load_i   (load_i),
    .din_i    (din_i),
    .preset_i (preset_i),
    .count_o  (count_o)
);

// File: tb/prio_updown_counter_tb.sv
`timescale 1ns/1ps
module prio_updown_counter_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b0, en = 1'b0, up = 1'b0, ld = 1'b0, pre = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] cnt_a, cnt_b;
    logic [W-1:0] mdl_a, mdl_b;
    int           n_chk = 0, n_bad = 0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    prio_updown_counter #(.WIDTH(W), .PRESET_VAL(9), .PRESET_WINS(1'b0)) u_dut (
        .clk_i(clk), .rst_i(rst), .en_i(en), .up_i(up), .load_i(ld),
        .din_i(din), .preset_i(pre), .count_o(cnt_a));

    prio_updown_counter #(.WIDTH(W), .PRESET_VAL(9), .PRESET_WINS(1'b1)) u_dut_swap (
        .clk_i(clk), .rst_i(rst), .en_i(en), .up_i(up), .load_i(ld),
        .din_i(din), .preset_i(pre), .count_o(cnt_b));

    // Reference model written from the requirements, not from the RTL.
    function automatic logic [W-1:0] ref_next(input logic [W-1:0] c, input bit swap,
                                              input logic r, p, e, l, u,
                                              input logic [W-1:0] d);
        if (swap && p) return W'(9);
        if (r)         return '0;
        if (p)         return W'(9);
        if (!e)        return c;
        if (l)         return d;
        return u ? W'(c + 1'b1) : W'(c - 1'b1);
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive the inputs away from the edge, take one edge, then compare both copies.
    task automatic apply(input string tag, input logic r, p, e, l, u, input logic [W-1:0] d);
        rst = r; pre = p; en = e; ld = l; up = u; din = d;
        @(posedge clk);
        #1;
        mdl_a = ref_next(mdl_a, 1'b0, r, p, e, l, u, d);
        mdl_b = ref_next(mdl_b, 1'b1, r, p, e, l, u, d);
        check({tag, " default"}, cnt_a, mdl_a);
        check({tag, " swapped"}, cnt_b, mdl_b);
    endtask

    task automatic t_reset();
        apply("R1 reset", 1, 0, 0, 0, 0, 8'h00);
        check("R1 reset literal", cnt_a, 8'h00);
        apply("R1 idle", 0, 0, 0, 0, 0, 8'h00);
        check("R1 no edge change", cnt_a, 8'h00);
    endtask

    task automatic t_up_wrap();
        apply("R2 load FD", 0, 0, 1, 1, 1, 8'hFD);
        for (int i = 0; i < 4; i++) apply("R2 up", 0, 0, 1, 0, 1, 8'h55);
        check("R2 wrap FF->00->01", cnt_a, 8'h01);
    endtask

    task automatic t_down_wrap();
        apply("R3 load 02", 0, 0, 1, 1, 0, 8'h02);
        for (int i = 0; i < 4; i++) apply("R3 down", 0, 0, 1, 0, 0, 8'hAA);
        check("R3 wrap 00->FE", cnt_a, 8'hFE);
    endtask

    task automatic t_hold_and_gated_load();
        apply("R4 hold up", 0, 0, 0, 0, 1, 8'h11);
        apply("R4 hold down", 0, 0, 0, 0, 0, 8'h22);
        check("R4 held", cnt_a, 8'hFE);
        apply("R6 load ignored", 0, 0, 0, 1, 1, 8'h3C);
        check("R6 held", cnt_a, 8'hFE);
    endtask

    task automatic t_load_beats_count();
        apply("R5 load vs up", 0, 0, 1, 1, 1, 8'h40);
        check("R5 value", cnt_a, 8'h40);
        apply("R5 load vs down", 0, 0, 1, 1, 0, 8'h80);
        check("R5 value down", cnt_a, 8'h80);
    endtask

    task automatic t_preset();
        apply("R7 preset disabled", 0, 1, 0, 0, 1, 8'h77);
        check("R7 value", cnt_a, 8'h09);
        apply("R5 reload", 0, 0, 1, 1, 1, 8'hC3);
        apply("R7 preset vs load", 0, 1, 1, 1, 1, 8'h12);
        check("R7 beats load", cnt_a, 8'h09);
    endtask

    task automatic t_collide();
        apply("R8 set", 0, 0, 1, 1, 1, 8'h5A);
        apply("R8 all strobes", 1, 1, 1, 1, 1, 8'h5A);
        check("R8 default clears", cnt_a, 8'h00);
        check("R9 swapped presets", cnt_b, 8'h09);
        apply("R9 reset alone", 1, 0, 1, 1, 0, 8'h33);
        check("R9 swapped clears", cnt_b, 8'h00);
    endtask

    task automatic t_random();
        for (int i = 0; i < 600; i++) begin
            logic [4:0] r5;
            r5 = 5'($urandom);
            apply("R2-random mix", r5[0] & r5[1] & r5[2], r5[1] & r5[3], r5[2] | r5[4],
                  r5[3], r5[4], W'($urandom));
        end
    endtask

    initial begin
        mdl_a = '0;
        mdl_b = '0;
        @(negedge clk);
        t_reset();
        t_up_wrap();
        t_down_wrap();
        t_hold_and_gated_load();
        t_load_beats_count();
        t_preset();
        t_collide();
        t_random();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule